// File: doc/BRIEF.md
# Digital Test Vector Sequencer

The block is a pattern-driven stimulus and capture engine for emulating serial buses on a group of general-purpose digital channels. Before a run, a host fills three per-step pattern stores through a simple register port: a channel value word, a channel drive-enable word and a single strobe bit. It then sets a first vector address, a vector count, a step divisor and an output skew, and issues a go command.

While the run is in progress, an address generator walks the stores in order. Each vector lasts a programmable number of clock cycles. Channels whose enable bit is set drive the stored value, and channels whose enable bit is clear are released so that the device under test can drive them. The spare strobe output follows the per-step strobe bit, so the host can mark chosen steps, such as valid data bits or the steps where the device answers. The pin inputs pass through a two-flop synchronizer. At the last cycle of each step, the synchronized pin state is written into a capture store at that vector's address. The host reads the capture store back once the done flag is set.

The output update within a step can be delayed by a skew of whole clock cycles, which places the data edges relative to the step boundary. DEPTH must be a power of two. NCH, AW+1 and the divisor width must not exceed HDW.

Top module: `vecseq_top`

## Requirements
- R1: After reset, pin_out, pin_oe and strobe_o are all zero, and the status word reads busy=0 and done=0.
- R2: A host write with host_sel 1, 2 or 3 stores the low bits of host_wdata at entry host_idx of the value store, the enable store or the strobe store (bit 0), respectively. A read with the same select and index returns the stored word. host_sel 4 reads the capture store, and host_sel 0 selects the control registers: index 0 is the first address, 1 the count, 2 the divisor, 3 the skew and 4 the command/status word.
- R3: Writing 1 to bit 0 of the command word while idle starts a run of COUNT vectors beginning at the first address, with addresses wrapping modulo DEPTH. The start clears done. The end of the run clears busy (status bit 0) and sets done (status bit 1). A go with COUNT=0 sets done at once and drives nothing.
- R4: Every step lasts DIV clock cycles, and a DIV of 0 counts as 1. Busy stays set for exactly COUNT*DIV cycles after the clock edge that accepts the go.
- R5: During a step, pin_out carries the step's value word and pin_oe carries its enable word. A channel whose enable bit is 0 is released (pin_oe low).
- R6: The outputs of a step (pin_out, pin_oe, strobe_o) change SKEW cycles after the step's first cycle. A SKEW larger than DIV-1 is clamped to DIV-1.
- R7: strobe_o is high during the steps whose strobe bit is 1 and low during the others. It returns low when the run ends.
- R8: For each step, the capture store entry at that step's address receives the pin_in value that stood three cycles before the step's last clock edge. This is the synchronizer latency, so the capture includes the step's own driven channels when SKEW <= DIV-4.
- R9: While a run is in progress, host writes to the pattern stores and the control registers are ignored, and a second go is ignored.
- R10: After a run ends, pin_out and pin_oe keep the last vector until the next run updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_sel | input | 3 | Region select: 0 control, 1 value, 2 enable, 3 strobe, 4 capture |
| host_idx | input | AW | Entry or register index |
| host_wdata | input | HDW | Host write data |
| host_rdata | output | HDW | Host read data for host_sel/host_idx (combinational) |
| pin_in | input | NCH | Channel pin states from the device under test |
| pin_out | output | NCH | Channel drive values |
| pin_oe | output | NCH | Channel drive enables (0 = released) |
| strobe_o | output | 1 | Programmable per-step trigger strobe |

## Verification
The bench uses the default build: 8 channels, 64 vectors and 16-bit host words. A depth of 64 lets a run start at entry 62 and wrap past the end of the stores into entry 0. The runs cover divisors of 1, 6, 8 and 20, skews of 0, 3 and 5, and an oversized skew. These reach the clamp, the case where a skew of DIV-1 makes a capture show the previous vector, and a divisor of 0 acting as 1. A device model on pin_in drives the released channels with a run-specific constant, so every capture word mixes driven and released bits.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;
    // Host region selects
    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_VAL  = 3'd1;
    localparam logic [2:0] SEL_OE   = 3'd2;
    localparam logic [2:0] SEL_STB  = 3'd3;
    localparam logic [2:0] SEL_CAP  = 3'd4;
    // Control register indices
    localparam int IX_START = 0;
    localparam int IX_COUNT = 1;
    localparam int IX_DIV   = 2;
    localparam int IX_SKEW  = 3;
    localparam int IX_CMD   = 4;
endpackage

// File: rtl/vecseq_sync.sv
module vecseq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = d;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q = r_q.s2;
endmodule

// File: rtl/vecseq_pattern_mem.sv
module vecseq_pattern_mem #(
    parameter int NCH   = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_sel,   // 1 value, 2 enable, 3 strobe
    input  logic [AW-1:0]  wr_idx,
    input  logic [NCH-1:0] wr_data,
    input  logic [AW-1:0]  eng_idx,
    output logic [NCH-1:0] eng_val,
    output logic [NCH-1:0] eng_oe,
    output logic           eng_stb,
    input  logic [AW-1:0]  host_idx,
    output logic [NCH-1:0] host_val,
    output logic [NCH-1:0] host_oe,
    output logic           host_stb
);
    typedef struct packed {
        logic [NCH-1:0] val;
        logic [NCH-1:0] oe;
        logic           stb;
    } vec_t;

    vec_t mem_d [DEPTH];
    vec_t mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            case (wr_sel)
                2'd1:    mem_d[wr_idx].val = wr_data;
                2'd2:    mem_d[wr_idx].oe  = wr_data;
                2'd3:    mem_d[wr_idx].stb = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign eng_val  = mem_q[eng_idx].val;
    assign eng_oe   = mem_q[eng_idx].oe;
    assign eng_stb  = mem_q[eng_idx].stb;
    assign host_val = mem_q[host_idx].val;
    assign host_oe  = mem_q[host_idx].oe;
    assign host_stb = mem_q[host_idx].stb;
endmodule

// File: rtl/vecseq_capture_mem.sv
module vecseq_capture_mem #(
    parameter int NCH   = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_idx,
    input  logic [NCH-1:0] wr_data,
    input  logic [AW-1:0]  rd_idx,
    output logic [NCH-1:0] rd_data
);
    logic [NCH-1:0] cap_d [DEPTH];
    logic [NCH-1:0] cap_q [DEPTH];

    always_comb begin
        cap_d = cap_q;
        if (wr_en) cap_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cap_q[i] <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_data = cap_q[rd_idx];
endmodule

// File: rtl/vecseq_engine.sv
module vecseq_engine #(
    parameter int NCH   = 8,
    parameter int DEPTH = 64,
    parameter int DIVW  = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [AW-1:0]   start,
    input  logic [CW-1:0]   count,
    input  logic [DIVW-1:0] div,
    input  logic [DIVW-1:0] skew,
    output logic [AW-1:0]   rd_idx,
    input  logic [NCH-1:0]  vec_val,
    input  logic [NCH-1:0]  vec_oe,
    input  logic            vec_stb,
    input  logic [NCH-1:0]  pin_sync,
    output logic [NCH-1:0]  pin_out,
    output logic [NCH-1:0]  pin_oe,
    output logic            strobe,
    output logic            busy,
    output logic            done,
    output logic            cap_we,
    output logic [AW-1:0]   cap_idx,
    output logic [NCH-1:0]  cap_data
);
    typedef struct packed {
        logic            run;
        logic            done;
        logic [DIVW-1:0] cnt;
        logic [AW-1:0]   addr;
        logic [CW-1:0]   left;
        logic [NCH-1:0]  out;
        logic [NCH-1:0]  oe;
        logic            stb;
    } eng_t;

    eng_t s_d, s_q;

    logic [DIVW-1:0] div_eff;
    logic [DIVW-1:0] last_tick;
    logic [DIVW-1:0] skew_eff;

    always_comb begin
        div_eff   = (div == '0) ? DIVW'(1) : div;
        last_tick = div_eff - DIVW'(1);
        skew_eff  = (skew > last_tick) ? last_tick : skew;
    end

    always_comb begin
        s_d    = s_q;
        cap_we = 1'b0;
        if (!s_q.run) begin
            if (go) begin
                s_d.run  = (count != '0);
                s_d.done = (count == '0);
                s_d.cnt  = '0;
                s_d.addr = start;
                s_d.left = count;
            end
        end else begin
            // output update, delayed by the skew inside the step
            if (s_q.cnt == skew_eff) begin
                s_d.out = vec_val;
                s_d.oe  = vec_oe;
                s_d.stb = vec_stb;
            end
            // capture on the step's last cycle, then advance
            if (s_q.cnt == last_tick) begin
                cap_we   = 1'b1;
                s_d.cnt  = '0;
                s_d.addr = s_q.addr + AW'(1);
                s_d.left = s_q.left - CW'(1);
                if (s_q.left == CW'(1)) begin
                    s_d.run  = 1'b0;
                    s_d.done = 1'b1;
                    s_d.stb  = 1'b0;
                end
            end else begin
                s_d.cnt = s_q.cnt + DIVW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_idx   = s_q.addr;
    assign pin_out  = s_q.out;
    assign pin_oe   = s_q.oe;
    assign strobe   = s_q.stb;
    assign busy     = s_q.run;
    assign done     = s_q.done;
    assign cap_idx  = s_q.addr;
    assign cap_data = pin_sync;
endmodule

// File: rtl/vecseq_top.sv
module vecseq_top
    import vecseq_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 64,
    parameter int HDW   = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_wr,
    input  logic [2:0]     host_sel,
    input  logic [AW-1:0]  host_idx,
    input  logic [HDW-1:0] host_wdata,
    output logic [HDW-1:0] host_rdata,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] pin_oe,
    output logic           strobe_o
);
    typedef struct packed {
        logic [AW-1:0]  start;
        logic [CW-1:0]  count;
        logic [HDW-1:0] div;
        logic [HDW-1:0] skew;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic           busy, done, go, pm_wr;
    logic [AW-1:0]  eng_idx, cap_idx;
    logic [NCH-1:0] eng_val, eng_oe, host_val, host_oe, pin_sync, cap_data, cap_rd;
    logic           eng_stb, host_stb, cap_we;

    // host write decode: everything is locked while a run is active
    always_comb begin
        cfg_d = cfg_q;
        go    = 1'b0;
        pm_wr = host_wr && !busy &&
                (host_sel == SEL_VAL || host_sel == SEL_OE || host_sel == SEL_STB);
        if (host_wr && !busy && host_sel == SEL_CTRL) begin
            case (host_idx)
                AW'(IX_START): cfg_d.start = host_wdata[AW-1:0];
                AW'(IX_COUNT): cfg_d.count = host_wdata[CW-1:0];
                AW'(IX_DIV):   cfg_d.div   = host_wdata;
                AW'(IX_SKEW):  cfg_d.skew  = host_wdata;
                AW'(IX_CMD):   go          = host_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // host read mux
    always_comb begin
        host_rdata = '0;
        case (host_sel)
            SEL_CTRL: begin
                case (host_idx)
                    AW'(IX_START): host_rdata[AW-1:0] = cfg_q.start;
                    AW'(IX_COUNT): host_rdata[CW-1:0] = cfg_q.count;
                    AW'(IX_DIV):   host_rdata         = cfg_q.div;
                    AW'(IX_SKEW):  host_rdata         = cfg_q.skew;
                    AW'(IX_CMD):   host_rdata[1:0]    = {done, busy};
                    default: ;
                endcase
            end
            SEL_VAL: host_rdata[NCH-1:0] = host_val;
            SEL_OE:  host_rdata[NCH-1:0] = host_oe;
            SEL_STB: host_rdata[0]       = host_stb;
            SEL_CAP: host_rdata[NCH-1:0] = cap_rd;
            default: ;
        endcase
    end

    vecseq_pattern_mem #(.NCH(NCH), .DEPTH(DEPTH)) u_pat (
        .clk(clk), .rst_n(rst_n),
        .wr_en(pm_wr), .wr_sel(host_sel[1:0]), .wr_idx(host_idx),
        .wr_data(host_wdata[NCH-1:0]),
        .eng_idx(eng_idx), .eng_val(eng_val), .eng_oe(eng_oe), .eng_stb(eng_stb),
        .host_idx(host_idx), .host_val(host_val), .host_oe(host_oe), .host_stb(host_stb)
    );

    vecseq_sync #(.W(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    vecseq_engine #(.NCH(NCH), .DEPTH(DEPTH), .DIVW(HDW)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go),
        .start(cfg_q.start), .count(cfg_q.count), .div(cfg_q.div), .skew(cfg_q.skew),
        .rd_idx(eng_idx), .vec_val(eng_val), .vec_oe(eng_oe), .vec_stb(eng_stb),
        .pin_sync(pin_sync), .pin_out(pin_out), .pin_oe(pin_oe), .strobe(strobe_o),
        .busy(busy), .done(done),
        .cap_we(cap_we), .cap_idx(cap_idx), .cap_data(cap_data)
    );

    vecseq_capture_mem #(.NCH(NCH), .DEPTH(DEPTH)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cap_we), .wr_idx(cap_idx), .wr_data(cap_data),
        .rd_idx(host_idx), .rd_data(cap_rd)
    );
endmodule

// File: rtl/vecseq_top_chk.sv
module vecseq_top_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           strobe_o,
    input logic [NCH-1:0] pin_out,
    input logic [NCH-1:0] pin_oe
);
    // R3: busy and done are never both set
    p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3: the end of a run raises done
    p_end_sets_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R3: the start of a run clears done
    p_start_clears_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done);

    // R7: strobe only inside a run
    p_strobe_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> busy);

    // R10: pins hold while the sequencer is idle
    p_pins_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind vecseq_top vecseq_top_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .strobe_o(strobe_o), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/vecseq_top_tb.sv
`timescale 1ns/1ps
module vecseq_top_tb;
    localparam int NCH = 8;
    localparam int DEPTH = 64;
    localparam int HDW = 16;
    localparam int AW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_wr = 1'b0;
    logic [2:0]     host_sel = '0;
    logic [AW-1:0]  host_idx = '0;
    logic [HDW-1:0] host_wdata = '0;
    logic [HDW-1:0] host_rdata;
    logic [NCH-1:0] pin_in, pin_out, pin_oe;
    logic           strobe_o;
    logic [NCH-1:0] dev_val = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int go_cyc = 0;
    bit finished = 0;

    logic [7:0] m_out [DEPTH];
    logic [7:0] m_oe  [DEPTH];
    logic       m_stb [DEPTH];
    logic [7:0] prev_out = '0;
    logic [7:0] prev_oe = '0;
    int r_start, r_cnt, r_div, r_skew;

    // device model drives the released channels
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & dev_val);

    vecseq_top #(.NCH(NCH), .DEPTH(DEPTH), .HDW(HDW)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .strobe_o(strobe_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] s, input int i, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = s; host_idx = i[AW-1:0]; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [2:0] s, input int i, output logic [15:0] d);
        host_sel = s; host_idx = i[AW-1:0];
        #0.5;
        d = host_rdata;
    endtask

    task automatic pm_write(input int k);
        m_out[k] = 8'((k * 37 + 5) & 255);
        case (k % 4)
            0: m_oe[k] = 8'hFF;
            1: m_oe[k] = 8'h0F;
            2: m_oe[k] = 8'hF0;
            default: m_oe[k] = 8'h00;
        endcase
        m_stb[k] = (k % 2) == 0;
        hw(3'd1, k, {8'h0, m_out[k]});
        hw(3'd2, k, {8'h0, m_oe[k]});
        hw(3'd3, k, {15'h0, m_stb[k]});
    endtask

    // step index in force after cycle n of the run, -1 before the first update
    function automatic int step_at(int n);
        int k;
        if (n < 1 + r_skew) return -1;
        k = (n - 1 - r_skew) / r_div;
        if (k > r_cnt - 1) k = r_cnt - 1;
        return k;
    endfunction

    function automatic logic [7:0] e_out(int n);
        int k = step_at(n);
        return (k < 0) ? prev_out : m_out[(r_start + k) % DEPTH];
    endfunction

    function automatic logic [7:0] e_oe(int n);
        int k = step_at(n);
        return (k < 0) ? prev_oe : m_oe[(r_start + k) % DEPTH];
    endfunction

    function automatic logic [7:0] e_pin(int n);
        return (e_oe(n) & e_out(n)) | (~e_oe(n) & dev_val);
    endfunction

    task automatic t_reset();
        logic [15:0] st;
        chk(pin_out == 8'h0, "R1 pin_out", pin_out, 0);
        chk(pin_oe == 8'h0, "R1 pin_oe", pin_oe, 0);
        chk(strobe_o == 1'b0, "R1 strobe", strobe_o, 0);
        hr(3'd0, 4, st);
        chk(st[1:0] == 2'b00, "R1 status", st, 0);
    endtask

    task automatic t_load();
        logic [15:0] d;
        for (int k = 0; k < 16; k++) pm_write(k);
        pm_write(62);
        pm_write(63);
        for (int k = 2; k < 5; k++) begin
            hr(3'd1, k, d); chk(d[7:0] == m_out[k], "R2 value readback", d, m_out[k]);
            hr(3'd2, k, d); chk(d[7:0] == m_oe[k], "R2 enable readback", d, m_oe[k]);
            hr(3'd3, k, d); chk(d[0] == m_stb[k], "R2 strobe readback", d, m_stb[k]);
        end
    endtask

    task automatic run_check(input int start, input int count, input int div, input int skew, input logic [7:0] dev);
        logic [15:0] st;
        int total;
        bit exp_stb;
        int k;
        hw(3'd0, 0, 16'(start));
        hw(3'd0, 1, 16'(count));
        hw(3'd0, 2, 16'(div));
        hw(3'd0, 3, 16'(skew));
        r_start = start; r_cnt = count;
        r_div = (div == 0) ? 1 : div;
        r_skew = (skew > r_div - 1) ? r_div - 1 : skew;
        dev_val = dev;
        repeat (4) @(posedge clk);
        hw(3'd0, 4, 16'h1);
        go_cyc = cyc;
        total = count * r_div;
        for (int n = 1; n <= total + 2; n++) begin
            @(posedge clk); #1;
            chk(pin_out == e_out(n - (cyc - go_cyc - n)), "R5/R6 pin_out", pin_out, e_out(n));
            chk(pin_oe == e_oe(n), "R5 pin_oe", pin_oe, e_oe(n));
            k = step_at(n);
            exp_stb = (k >= 0 && n < total) ? m_stb[(r_start + k) % DEPTH] : 1'b0;
            chk(strobe_o == exp_stb, "R7 strobe", strobe_o, exp_stb);
            hr(3'd0, 4, st);
            chk(st[0] == (n < total), "R4 busy length", st, (n < total));
            chk(st[1] == (n >= total), "R3 done", st, (n >= total));
        end
        for (int j = 0; j < count; j++) begin
            hr(3'd4, (start + j) % DEPTH, st);
            chk(st[7:0] == e_pin((j + 1) * r_div - 3), "R8 capture", st, e_pin((j + 1) * r_div - 3));
        end
        prev_out = m_out[(start + count - 1) % DEPTH];
        prev_oe  = m_oe[(start + count - 1) % DEPTH];
        repeat (3) @(posedge clk);
        #1;
        chk(pin_out == prev_out, "R10 hold out", pin_out, prev_out);
        chk(pin_oe == prev_oe, "R10 hold oe", pin_oe, prev_oe);
    endtask

    task automatic t_zero_count();
        logic [15:0] st;
        hw(3'd0, 1, 16'h0);
        hw(3'd0, 4, 16'h1);
        @(posedge clk); #1;
        hr(3'd0, 4, st);
        chk(st[1:0] == 2'b10, "R3 zero count done", st, 2);
        chk(pin_out == prev_out, "R3 zero count pins", pin_out, prev_out);
        chk(strobe_o == 1'b0, "R3 zero count strobe", strobe_o, 0);
    endtask

    task automatic t_busy_reject();
        logic [15:0] st;
        int n;
        hw(3'd0, 0, 16'h0);
        hw(3'd0, 1, 16'h2);
        hw(3'd0, 2, 16'd20);
        hw(3'd0, 3, 16'h0);
        hw(3'd0, 4, 16'h1);
        go_cyc = cyc;
        repeat (4) @(posedge clk);
        hw(3'd1, 0, {8'h0, ~m_out[0]});
        hw(3'd0, 2, 16'd3);
        hw(3'd0, 4, 16'h1);
        n = 0;
        for (int t = 0; t < 200; t++) begin
            @(posedge clk); #1;
            hr(3'd0, 4, st);
            if (st[1]) begin
                n = cyc - go_cyc;
                break;
            end
        end
        chk(n == 40, "R9 run length unchanged", n, 40);
        hr(3'd1, 0, st);
        chk(st[7:0] == m_out[0], "R9 value write ignored", st, m_out[0]);
        hr(3'd0, 2, st);
        chk(st == 16'd20, "R9 divisor write ignored", st, 20);
        prev_out = m_out[1];
        prev_oe  = m_oe[1];
        chk(pin_out == prev_out, "R10 hold after reject run", pin_out, prev_out);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_load();
        run_check(0, 4, 6, 0, 8'hC3);
        run_check(62, 4, 6, 5, 8'h3C);
        run_check(4, 3, 0, 7, 8'h96);
        run_check(8, 3, 8, 3, 8'h5A);
        t_zero_count();
        t_busy_reject();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule